// File: doc/BRIEF.md
# Row-Binary to Column-Code Transposer

This block turns one finished print line, held in an external buffer as row-binary words, into a stream of per-column punch codes. The line has 72 print columns and 12 punch rows. Each row occupies two 36-bit words: the first word covers columns 0 to 35 and the second covers columns 36 to 71. Within a word, the leftmost column sits in the most significant bit. After a start pulse the block reads the whole buffer through a simple read port with one cycle of latency and keeps a private copy. It then presents the columns in order, one per accepted handshake.

Each emitted beat carries the column index and a 12-bit code, with one bit per punch row. While the columns go out, the block keeps track of the last column that has any row punched. When the final column has been accepted, it raises a one-cycle done pulse. In that cycle it also presents the line length with the trailing blank columns removed. The downstream logic that turns column codes into characters, and the logic that trims the printed text, both use this stream and this length.

Top module: `rowbin_col_transposer`

## Requirements
- R1: While reset is high and in the cycle after it, `col_valid`, `line_done` and `buf_rd_en` are 0 and `line_len` is 0. Reset taken in the middle of a line abandons that line.
- R2: An accepted start reads buffer words 0 to 23 in ascending order, one address per cycle, with `buf_rd_en` high for exactly 24 consecutive cycles. The data for an address is taken from `buf_rd_data` in the cycle after that address is presented.
- R3: Columns are presented in ascending order from 0 to 71, each exactly once. A beat is accepted in a cycle where `col_valid` and `col_ready` are both high. While `col_valid` is high and `col_ready` is low, the next cycle keeps `col_valid` high and keeps `col_idx` and `col_code` unchanged.
- R4: For column c, bit r of `col_code` (bit 0 being buffer row 0) equals bit (35 - c mod 36) of buffer word 2*r + c/36 (integer division).
- R5: Column 0 takes the most significant bit (bit 35) of the even word of each row. Column 35 takes bit 0 of that word. Column 36 takes bit 35 of the odd word, and column 71 takes bit 0 of the odd word.
- R6: `line_len` at the done pulse equals one plus the index of the highest column whose code is nonzero. A column whose code is all zero is blank. An all-blank line gives 0, and a line whose column 71 is punched gives 72.
- R7: `line_done` is high for exactly one cycle per line. That cycle is the one right after column 71 is accepted, and `col_valid` is 0 during it.
- R8: A start pulse while a line is being read or presented has no effect. The read sequence and the column sequence of that line carry on unchanged.
- R9: `line_len` keeps its value after the done pulse until the next accepted start, which clears it to 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin converting the line in the buffer (taken only when idle) |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_rd_addr | output | 5 | Buffer word address |
| buf_rd_data | input | 36 | Buffer word, valid the cycle after the strobe |
| col_valid | output | 1 | A column beat is presented |
| col_ready | input | 1 | Consumer accepts the beat |
| col_idx | output | 7 | Column number, 0 to 71 |
| col_code | output | 12 | Punch rows present in the column, bit r = buffer row r |
| line_done | output | 1 | One-cycle pulse after the last column |
| line_len | output | 7 | Line length without trailing blank columns |

## Verification
The hardest case to reach from the ports is a line whose only punched column sits at a word seam: column 35, 36 or 71. Here a wrong word select or bit reversal shows up only in the trimmed length and a single code. Another hard case is back-pressure that holds the last column while the done logic is poised. The stimulus table places single punches at each seam in different rows. It also builds random lines cleared above a chosen column, and runs half of them with a throttled ready pattern. Directed runs add start pulses during both the read phase and the presentation phase, and a reset in the middle of a line.

// File: rtl/colxp_pkg.sv
package colxp_pkg;

    typedef enum logic [1:0] {
        XP_IDLE = 2'd0,
        XP_LOAD = 2'd1,
        XP_EMIT = 2'd2
    } xp_state_e;

    // Which word of a row holds a column.
    function automatic int word_sel(input int col, input int word_w);
        return col / word_w;
    endfunction

    // Bit position of a column inside its word; leftmost column is the MSB.
    function automatic int bit_sel(input int col, input int word_w);
        return word_w - 1 - (col % word_w);
    endfunction

endpackage

// File: rtl/xp_line_loader.sv
module xp_line_loader #(
    parameter int WORD_W    = 36,
    parameter int BUF_WORDS = 24,
    parameter int ADDR_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              begin_load,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] words [BUF_WORDS],
    output logic              load_done
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BUF_WORDS - 1);

    logic              issuing;
    logic [ADDR_W-1:0] issue_addr;
    logic              cap_vld;
    logic [ADDR_W-1:0] cap_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            issuing    <= 1'b0;
            issue_addr <= '0;
            cap_vld    <= 1'b0;
            cap_addr   <= '0;
        end else begin
            cap_vld  <= issuing;
            cap_addr <= issue_addr;
            if (begin_load) begin
                issuing    <= 1'b1;
                issue_addr <= '0;
            end else if (issuing) begin
                if (issue_addr == LAST_ADDR) begin
                    issuing <= 1'b0;
                end else begin
                    issue_addr <= issue_addr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BUF_WORDS; i++) begin
                words[i] <= '0;
            end
        end else if (cap_vld) begin
            words[cap_addr] <= rd_data;
        end
    end

    assign rd_en     = issuing;
    assign rd_addr   = issue_addr;
    assign load_done = cap_vld && (cap_addr == LAST_ADDR);

endmodule

// File: rtl/xp_column_gather.sv
module xp_column_gather #(
    parameter int WORD_W        = 36,
    parameter int NUM_ROWS      = 12,
    parameter int WORDS_PER_ROW = 2,
    parameter int BUF_WORDS     = 24,
    parameter int COL_W         = 7
) (
    input  logic [COL_W-1:0]    col_idx,
    input  logic [WORD_W-1:0]   words [BUF_WORDS],
    output logic [NUM_ROWS-1:0] code
);
    localparam int WIDX_W = $clog2(BUF_WORDS);
    localparam int BPOS_W = $clog2(WORD_W);

    logic [BPOS_W-1:0] bpos;
    int                wsel;

    always_comb begin
        wsel = colxp_pkg::word_sel(int'(col_idx), WORD_W);
        bpos = BPOS_W'(colxp_pkg::bit_sel(int'(col_idx), WORD_W));
    end

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        logic [WIDX_W-1:0] widx;
        always_comb begin
            widx    = WIDX_W'(r * WORDS_PER_ROW + wsel);
            code[r] = words[widx][bpos];
        end
    end

endmodule

// File: rtl/xp_blank_trim.sv
module xp_blank_trim #(
    parameter int NUM_ROWS = 12,
    parameter int COL_W    = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                take,
    input  logic [COL_W-1:0]    col_idx,
    input  logic [NUM_ROWS-1:0] code,
    output logic [COL_W-1:0]    line_len
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            line_len <= '0;
        end else if (take && (|code)) begin
            line_len <= col_idx + 1'b1;
        end
    end

endmodule

// File: rtl/rowbin_col_transposer.sv
module rowbin_col_transposer #(
    parameter int NUM_COLS = 72,
    parameter int NUM_ROWS = 12,
    parameter int WORD_W   = 36
) (
    input  logic                                              clk,
    input  logic                                              rst,
    input  logic                                              start,
    output logic                                              buf_rd_en,
    output logic [$clog2(NUM_ROWS*((NUM_COLS+WORD_W-1)/WORD_W))-1:0] buf_rd_addr,
    input  logic [WORD_W-1:0]                                 buf_rd_data,
    output logic                                              col_valid,
    input  logic                                              col_ready,
    output logic [$clog2(NUM_COLS+1)-1:0]                     col_idx,
    output logic [NUM_ROWS-1:0]                               col_code,
    output logic                                              line_done,
    output logic [$clog2(NUM_COLS+1)-1:0]                     line_len
);
    import colxp_pkg::*;

    localparam int WORDS_PER_ROW = (NUM_COLS + WORD_W - 1) / WORD_W;
    localparam int BUF_WORDS     = NUM_ROWS * WORDS_PER_ROW;
    localparam int ADDR_W        = $clog2(BUF_WORDS);
    localparam int COL_W         = $clog2(NUM_COLS + 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    xp_state_e         state;
    logic [COL_W-1:0]  idx_q;
    logic              done_q;
    logic              start_ok;
    logic              load_done;
    logic              fire;
    logic              fire_last;
    logic [WORD_W-1:0] words [BUF_WORDS];

    assign start_ok  = start && (state == XP_IDLE);
    assign col_valid = (state == XP_EMIT);
    assign fire      = col_valid && col_ready;
    assign fire_last = fire && (idx_q == LAST_COL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= XP_IDLE;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= fire_last;
            case (state)
                XP_IDLE: if (start_ok) state <= XP_LOAD;
                XP_LOAD: if (load_done) begin
                    state <= XP_EMIT;
                    idx_q <= '0;
                end
                XP_EMIT: if (fire) begin
                    if (fire_last) begin
                        state <= XP_IDLE;
                        idx_q <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state <= XP_IDLE;
            endcase
        end
    end

    xp_line_loader #(
        .WORD_W   (WORD_W),
        .BUF_WORDS(BUF_WORDS),
        .ADDR_W   (ADDR_W)
    ) u_loader (
        .clk       (clk),
        .rst       (rst),
        .begin_load(start_ok),
        .rd_en     (buf_rd_en),
        .rd_addr   (buf_rd_addr),
        .rd_data   (buf_rd_data),
        .words     (words),
        .load_done (load_done)
    );

    xp_column_gather #(
        .WORD_W       (WORD_W),
        .NUM_ROWS     (NUM_ROWS),
        .WORDS_PER_ROW(WORDS_PER_ROW),
        .BUF_WORDS    (BUF_WORDS),
        .COL_W        (COL_W)
    ) u_gather (
        .col_idx(idx_q),
        .words  (words),
        .code   (col_code)
    );

    xp_blank_trim #(
        .NUM_ROWS(NUM_ROWS),
        .COL_W   (COL_W)
    ) u_trim (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_ok),
        .take    (fire),
        .col_idx (idx_q),
        .code    (col_code),
        .line_len(line_len)
    );

    assign col_idx   = idx_q;
    assign line_done = done_q;

endmodule

// File: rtl/xp_checker.sv
module xp_checker #(
    parameter int NUM_COLS = 72,
    parameter int NUM_ROWS = 12,
    parameter int WORD_W   = 36
) (
    input logic                                              clk,
    input logic                                              rst,
    input logic                                              start,
    input logic                                              buf_rd_en,
    input logic [$clog2(NUM_ROWS*((NUM_COLS+WORD_W-1)/WORD_W))-1:0] buf_rd_addr,
    input logic                                              col_valid,
    input logic                                              col_ready,
    input logic [$clog2(NUM_COLS+1)-1:0]                     col_idx,
    input logic [NUM_ROWS-1:0]                               col_code,
    input logic                                              line_done,
    input logic [$clog2(NUM_COLS+1)-1:0]                     line_len
);
    localparam int ADDR_W = $clog2(NUM_ROWS * ((NUM_COLS + WORD_W - 1) / WORD_W));
    localparam int COL_W  = $clog2(NUM_COLS + 1);

    p_rd_step_r2: assert property (@(posedge clk) disable iff (rst)
        buf_rd_en && $past(buf_rd_en) |-> buf_rd_addr == ADDR_W'($past(buf_rd_addr) + 1));

    p_hold_stall_r3: assert property (@(posedge clk) disable iff (rst)
        col_valid && !col_ready |=> col_valid && $stable(col_idx) && $stable(col_code));

    p_idx_step_r3: assert property (@(posedge clk) disable iff (rst)
        col_valid && col_ready && (col_idx != COL_W'(NUM_COLS - 1))
        |=> col_valid && (col_idx == COL_W'($past(col_idx) + 1)));

    p_len_bound_r6: assert property (@(posedge clk) disable iff (rst)
        line_len <= COL_W'(NUM_COLS));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        line_done |=> !line_done);

    p_done_follows_last_r7: assert property (@(posedge clk) disable iff (rst)
        col_valid && col_ready && (col_idx == COL_W'(NUM_COLS - 1)) |=> line_done && !col_valid);

    p_len_held_r9: assert property (@(posedge clk) disable iff (rst)
        line_done && !start |=> $stable(line_len));

endmodule

bind rowbin_col_transposer xp_checker #(
    .NUM_COLS(NUM_COLS),
    .NUM_ROWS(NUM_ROWS),
    .WORD_W  (WORD_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .buf_rd_en  (buf_rd_en),
    .buf_rd_addr(buf_rd_addr),
    .col_valid  (col_valid),
    .col_ready  (col_ready),
    .col_idx    (col_idx),
    .col_code   (col_code),
    .line_done  (line_done),
    .line_len   (line_len)
);

// File: tb/rowbin_col_transposer_test.sv
`timescale 1ns/100ps
module rowbin_col_transposer_test;

    localparam int NCOL = 72;
    localparam int NROW = 12;
    localparam int WW   = 36;
    localparam int NWRD = 24;

    typedef struct packed {
        int kind;
        int col;
        int row;
        int rmode;
        int exp_len;
    } vec_t;

    // kind 0: blank line; 1: single punch at (row,col); 2: random, cleared above col, punch at (row,col)
    localparam vec_t VECS [8] = '{
        '{0,  0,  0, 0,  0},
        '{1,  0,  0, 0,  1},
        '{1, 71, 11, 1, 72},
        '{1, 35, 11, 0, 36},
        '{1, 36,  5, 1, 37},
        '{2, 49,  3, 1, 50},
        '{2, 71,  0, 0, 72},
        '{2, 10,  7, 1, 11}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          buf_rd_en;
    logic [4:0]    buf_rd_addr;
    logic [35:0]   buf_rd_data = '0;
    logic          col_valid;
    logic          col_ready = 1'b0;
    logic [6:0]    col_idx;
    logic [11:0]   col_code;
    logic          line_done;
    logic [6:0]    line_len;

    logic [35:0]   mem [NWRD];
    int            checks = 0;
    int            failures = 0;
    logic [31:0]   rng;

    always #2.5 clk = ~clk;

    rowbin_col_transposer uut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .buf_rd_en  (buf_rd_en),
        .buf_rd_addr(buf_rd_addr),
        .buf_rd_data(buf_rd_data),
        .col_valid  (col_valid),
        .col_ready  (col_ready),
        .col_idx    (col_idx),
        .col_code   (col_code),
        .line_done  (line_done),
        .line_len   (line_len)
    );

    always @(posedge clk) begin
        if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] model_code(input int c);
        logic [11:0] k;
        for (int r = 0; r < NROW; r++) k[r] = mem[2 * r + c / WW][WW - 1 - (c % WW)];
        return k;
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic fill_line(input int kind, input int col, input int row, input int seed);
        rng = 32'h1234_5678 + 32'(seed) * 32'h9E37;
        for (int w = 0; w < NWRD; w++) begin
            if (kind == 2) begin
                rng = next_rng(rng);
                mem[w][31:0] = rng;
                rng = next_rng(rng);
                mem[w][35:32] = rng[3:0];
                for (int b = 0; b < WW; b++) begin
                    if ((w % 2) * WW + (WW - 1 - b) > col) mem[w][b] = 1'b0;
                end
            end else begin
                mem[w] = '0;
            end
        end
        if (kind != 0) mem[2 * row + col / WW][WW - 1 - (col % WW)] = 1'b1;
    endtask

    task automatic run_line(input int rmode, input int exp_len, input int inject_at, input string tag);
        int exp_addr = 0;
        int exp_col  = 0;
        int addr_err = 0;
        int ord_err  = 0;
        int code_err = 0;
        int stall_err = 0;
        int dones    = 0;
        int len_seen = -1;
        bit v_at_done = 1'b0;
        bit stalled  = 1'b0;
        int prev_idx = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 2000; cyc++) begin
            col_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 2);
            #1;
            if (cyc == 0) check(line_len == 0, {"R9 length cleared by start ", tag}, line_len, 0);
            if (buf_rd_en) begin
                if (int'(buf_rd_addr) != exp_addr) addr_err++;
                exp_addr++;
            end
            if (stalled && (!col_valid || int'(col_idx) != prev_idx)) stall_err++;
            if (col_valid && col_ready) begin
                if (int'(col_idx) != exp_col) ord_err++;
                if (col_code != model_code(int'(col_idx))) code_err++;
                exp_col++;
            end
            stalled  = col_valid && !col_ready;
            prev_idx = int'(col_idx);
            start = (cyc == inject_at);
            if (line_done) begin
                dones++;
                len_seen  = int'(line_len);
                v_at_done = col_valid;
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #1;
            if (line_done) dones++;
            if (buf_rd_en) exp_addr++;
        end
        check(addr_err == 0 && exp_addr == NWRD, {"R2 read order ", tag}, exp_addr, NWRD);
        check(ord_err == 0 && exp_col == NCOL, {"R3 column order ", tag}, exp_col, NCOL);
        check(stall_err == 0, {"R3 hold under stall ", tag}, stall_err, 0);
        check(code_err == 0, {"R4 R5 column codes ", tag}, code_err, 0);
        check(len_seen == exp_len, {"R6 trimmed length ", tag}, len_seen, exp_len);
        check(dones == 1 && !v_at_done, {"R7 single done ", tag}, dones, 1);
        check(int'(line_len) == exp_len, {"R9 length held ", tag}, line_len, exp_len);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        for (int w = 0; w < NWRD; w++) mem[w] = '0;
        repeat (3) @(negedge clk);
        #1;
        check(!col_valid && !line_done && !buf_rd_en && line_len == 0, "R1 in reset", col_valid, 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!col_valid && !line_done && !buf_rd_en && line_len == 0, "R1 after reset", line_len, 0);

        for (int i = 0; i < 8; i++) begin
            fill_line(VECS[i].kind, VECS[i].col, VECS[i].row, i + 1);
            run_line(VECS[i].rmode, VECS[i].exp_len, -1, $sformatf("vec%0d", i));
        end

        // R8: start during the read phase, then during column output
        fill_line(2, 60, 9, 21);
        run_line(1, 61, 5, "r8_load");
        fill_line(1, 36, 2, 22);
        run_line(0, 37, 50, "r8_emit");

        // R9: length holds across idle cycles
        repeat (6) @(negedge clk);
        #1;
        check(line_len == 37, "R9 idle hold", line_len, 37);

        // R1: reset in the middle of a line
        fill_line(2, 71, 4, 23);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (35) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!col_valid && !line_done && !buf_rd_en && line_len == 0, "R1 mid-line reset", col_valid, 0);
        repeat (5) @(negedge clk);
        #1;
        check(!col_valid && !line_done, "R1 stays idle", col_valid, 0);

        fill_line(1, 71, 11, 24);
        run_line(0, 72, -1, "after_reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule